// File: doc/BRIEF.md
# Parallel-to-Serial Display Link Transmitter

The block turns one 21-bit pixel word per pixel-clock period into three serial data lanes, each carrying seven bits per period, plus a fourth lane that forwards a clock with the pixel period. The word holds eighteen colour bits (six each of red, green and blue) and three timing bits (line sync, frame sync and data enable). Everything runs on a bit clock supplied from outside at exactly seven times the pixel rate. The pixel clock itself is sampled as a signal in that domain. A strobe-select input picks which pixel-clock edge captures the word.

The active-low power-down input is the block's reset. While it is low, the output enable is off and every lane bit is low. After release, the block waits until the pixel clock has run for two full periods before it drives data. If the pixel clock stops while power-down is released, all lanes fall low and the block re-acquires by itself once the clock returns. No power-down cycle is needed. The pixel clock and the word may start before or after release.

The controller has three states. In `ST_OFF`, power-down is asserted. In `ST_ACQUIRE`, the lanes are enabled and held low while capture edges are counted. In `ST_RUN`, the block serializes. The transitions are:
- Release: `ST_OFF` to `ST_ACQUIRE` on the first bit-clock edge after power-down goes high.
- Lock: `ST_ACQUIRE` to `ST_RUN` on the third capture edge seen without a loss.
- Loss: `ST_RUN` to `ST_ACQUIRE` when the missing-clock flag is set and no capture edge is present.
- Power-down: any state to `ST_OFF` asynchronously when power-down goes low.

Top module: `pixlink_tx`

## Requirements
- R1: With `strobe_rise` high, the word serialized for a period is the value `pix_word` held just before a rising edge of `pix_clk`; a change of `pix_word` at the falling edge is not captured.
- R2: With `strobe_rise` low, the captured word is the value held just before a falling edge of `pix_clk`.
- R3: Word layout is red in bits 5:0, green in 11:6, blue in 17:12, line sync 18, frame sync 19, data enable 20. In slot s (0 to 6), lane k carries word bit 7k+s, so lane 0 sends bits 0..6, lane 1 sends 7..13 and lane 2 sends 14..20, lowest first.
- R4: Each slot lasts one bit-clock cycle. Slot 0 of a captured word appears on the third bit-clock rising edge after the capture edge of `pix_clk`, and slots follow without gaps.
- R5: In `ST_RUN`, `lane_clk` follows the pattern 1,1,0,0,0,1,1 over slots 0 to 6.
- R6: If 32 consecutive bit-clock cycles pass with no `pix_clk` edge of either polarity while `pd_n` is high, `lane_data` and `lane_clk` go low and `lane_oe` stays high.
- R7: After power-down release or after a loss, lanes stay low until the third capture edge. The word captured at that edge is the first one sent.
- R8: While `pd_n` is low, `lane_oe`, `lane_clk` and `lane_data` are low, taking effect without waiting for a clock edge.
- R9: After the pixel clock stops and restarts without any change on `pd_n`, serialization resumes per R7 with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| pd_n | input | 1 | Active-low power-down and asynchronous reset |
| pix_clk | input | 1 | Pixel clock, sampled in the bit-clock domain |
| strobe_rise | input | 1 | 1: capture on rising pixel-clock edge, 0: on falling edge |
| pix_word | input | 21 | Pixel word (colour and timing bits) |
| lane_data | output | 3 | Serial data lane bits |
| lane_clk | output | 1 | Forwarded clock lane bit |
| lane_oe | output | 1 | Output enable for the lane drivers (0 = tri-state) |

## Verification
A slot counter that is off by one rotates all three data lanes and the clock lane at once. This shows within one bit-clock cycle of the third capture edge. A capture on the wrong edge, or a data pipe whose depth does not match the clock synchronizer, shows up as the next period's word appearing on the lanes. A wrong loss threshold or relock count moves the cycle in which the lanes fall to zero or come back. The bench samples the lanes in every slot, so such an error appears at the first affected slot.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_RUN     = 2'd2
    } link_state_t;

endpackage

// File: rtl/ltx_edge_capture.sv
module ltx_edge_capture #(
    parameter int WORD_W      = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              rise_sel,
    input  logic [WORD_W-1:0] word_in,
    output logic              cap,
    output logic              any_edge,
    output logic [WORD_W-1:0] word_cap
);
    localparam int PIPE = SYNC_STAGES + 1;

    logic [SYNC_STAGES:0] ps;
    logic [WORD_W-1:0]    dp [PIPE];

    // pixel clock synchronizer plus one history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps <= '0;
        end else begin
            ps <= {ps[SYNC_STAGES-1:0], pix_clk};
        end
    end

    // word pipe matched to the history stage: holds value before the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE; i++) dp[i] <= '0;
        end else begin
            dp[0] <= word_in;
            for (int i = 1; i < PIPE; i++) dp[i] <= dp[i-1];
        end
    end

    logic rise_seen, fall_seen;
    assign rise_seen = ps[SYNC_STAGES-1] & ~ps[SYNC_STAGES];
    assign fall_seen = ~ps[SYNC_STAGES-1] & ps[SYNC_STAGES];
    assign cap       = rise_sel ? rise_seen : fall_seen;
    assign any_edge  = rise_seen | fall_seen;
    assign word_cap  = dp[PIPE-1];

endmodule

// File: rtl/ltx_clock_monitor.sv
module ltx_clock_monitor #(
    parameter int LOSS_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    output logic missing
);
    localparam int GW = $clog2(LOSS_LIMIT + 1);

    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (edge_seen) begin
            gap <= '0;
        end else if (gap != GW'(LOSS_LIMIT)) begin
            gap <= gap + 1'b1;
        end
    end

    assign missing = (gap == GW'(LOSS_LIMIT));

    AST_LOSS_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (missing && !edge_seen) |=> missing); // R6

endmodule

// File: rtl/ltx_lane_shifter.sv
module ltx_lane_shifter #(
    parameter int               LANES       = 3,
    parameter int               SLOTS       = 7,
    parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [LANES*SLOTS-1:0]   word,
    output logic [LANES-1:0]         lane_bits,
    output logic                     clk_bit
);
    localparam int WORD_W = LANES * SLOTS;
    localparam int SW     = $clog2(SLOTS);

    logic [WORD_W-1:0] hold;
    logic [SW-1:0]     slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            slot <= '0;
        end else if (load) begin
            hold <= word;
            slot <= '0;
        end else if (slot == SW'(SLOTS - 1)) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [SLOTS-1:0] lane_word;
            assign lane_word    = hold[k*SLOTS +: SLOTS];
            assign lane_bits[k] = lane_word[slot];
        end
    endgenerate

    assign clk_bit = CLK_PATTERN[slot];

    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (slot == '0) && (hold == $past(word))); // R4
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && slot != SW'(SLOTS - 1)) |=> slot == $past(slot) + 1'b1); // R4

endmodule

// File: rtl/pixlink_tx.sv
module pixlink_tx
    import pixlink_pkg::*;
#(
    parameter int LANES          = 3,
    parameter int SLOTS          = 7,
    parameter int SYNC_STAGES    = 2,
    parameter int LOSS_LIMIT     = 32,
    parameter int RELOCK_PERIODS = 2
) (
    input  logic                   bit_clk,
    input  logic                   pd_n,
    input  logic                   pix_clk,
    input  logic                   strobe_rise,
    input  logic [LANES*SLOTS-1:0] pix_word,
    output logic [LANES-1:0]       lane_data,
    output logic                   lane_clk,
    output logic                   lane_oe
);
    localparam int WORD_W = LANES * SLOTS;
    localparam int AW     = $clog2(RELOCK_PERIODS + 1);

    logic              cap, any_edge, missing, clk_bit;
    logic [WORD_W-1:0] word_cap;
    logic [LANES-1:0]  lane_bits;

    ltx_edge_capture #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(bit_clk), .rst_n(pd_n), .pix_clk(pix_clk), .rise_sel(strobe_rise),
        .word_in(pix_word), .cap(cap), .any_edge(any_edge), .word_cap(word_cap)
    );

    ltx_clock_monitor #(.LOSS_LIMIT(LOSS_LIMIT)) u_mon (
        .clk(bit_clk), .rst_n(pd_n), .edge_seen(any_edge), .missing(missing)
    );

    ltx_lane_shifter #(.LANES(LANES), .SLOTS(SLOTS)) u_shift (
        .clk(bit_clk), .rst_n(pd_n), .load(cap), .word(word_cap),
        .lane_bits(lane_bits), .clk_bit(clk_bit)
    );

    link_state_t    state, state_nx;
    logic [AW-1:0]  acq_cnt, acq_cnt_nx;

    // state register
    always_ff @(posedge bit_clk or negedge pd_n) begin
        if (!pd_n) begin
            state   <= ST_OFF;
            acq_cnt <= '0;
        end else begin
            state   <= state_nx;
            acq_cnt <= acq_cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx   = state;
        acq_cnt_nx = acq_cnt;
        unique case (state)
            ST_OFF: begin
                state_nx   = ST_ACQUIRE;
                acq_cnt_nx = '0;
            end
            ST_ACQUIRE: begin
                if (cap) begin
                    if (acq_cnt == AW'(RELOCK_PERIODS)) begin
                        state_nx   = ST_RUN;
                        acq_cnt_nx = '0;
                    end else begin
                        acq_cnt_nx = acq_cnt + 1'b1;
                    end
                end else if (missing) begin
                    acq_cnt_nx = '0;
                end
            end
            ST_RUN: begin
                if (missing && !cap) begin
                    state_nx   = ST_ACQUIRE;
                    acq_cnt_nx = '0;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        lane_oe   = (state != ST_OFF);
        lane_data = (state == ST_RUN) ? lane_bits : '0;
        lane_clk  = (state == ST_RUN) ? clk_bit : 1'b0;
    end

    AST_LOSS_LEAVES_RUN: assert property (@(posedge bit_clk) disable iff (!pd_n)
        (state == ST_RUN && missing && !cap) |=> state == ST_ACQUIRE); // R6
    AST_RUN_ENTRY_ON_CAP: assert property (@(posedge bit_clk) disable iff (!pd_n)
        $rose(state == ST_RUN) |-> $past(cap)); // R7
    AST_CAP_CLEARS_LOSS: assert property (@(posedge bit_clk) disable iff (!pd_n)
        cap |=> !missing); // R6

endmodule

// File: tb/pixlink_tx_tb.sv
module pixlink_tx_tb;

    logic        bit_clk = 1'b0;
    logic        pd_n = 1'b0;
    logic        pix_clk = 1'b0;
    logic        strobe_rise = 1'b1;
    logic [20:0] pix_word = '0;
    logic [2:0]  lane_data;
    logic        lane_clk;
    logic        lane_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench tracking of what should be on the lanes
    logic [20:0] last_din  = '0;
    logic [20:0] word_cur  = '0;
    logic [20:0] word_prev = '0;
    bit          run_cur   = 1'b0;
    bit          run_prev  = 1'b0;
    int          cap_cnt   = 0;

    localparam logic [6:0] CLK_PAT = 7'b1100011;

    always #5 bit_clk = ~bit_clk;

    pixlink_tx u_dut (
        .bit_clk(bit_clk), .pd_n(pd_n), .pix_clk(pix_clk),
        .strobe_rise(strobe_rise), .pix_word(pix_word),
        .lane_data(lane_data), .lane_clk(lane_clk), .lane_oe(lane_oe)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {oe,clk,data} actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_slot(input string tag, input bit run, input logic [20:0] w, input int s);
        logic [4:0] exp;
        if (run) exp = {1'b1, CLK_PAT[s], w[14+s], w[7+s], w[s]};
        else     exp = 5'b10000;
        check(tag, {lane_oe, lane_clk, lane_data}, exp);
    endtask

    task automatic forget_lock();
        cap_cnt = 0;
        run_cur = 1'b0;
    endtask

    // one pixel period: capture edge at slot 0, other edge at 4
    task automatic pix_period(input string tag, input logic [20:0] nxt);
        for (int c = 0; c < 7; c++) begin
            @(negedge bit_clk);
            if (c == 0) begin
                word_prev = word_cur;
                run_prev  = run_cur;
                word_cur  = last_din;
                cap_cnt++;
                run_cur   = (cap_cnt >= 3);
                pix_clk   = strobe_rise;
                pix_word  = nxt;
                last_din  = nxt;
            end
            if (c == 4) pix_clk = ~strobe_rise;
            if (c < 3) check_slot(tag, run_prev, word_prev, c + 4);
            else       check_slot(tag, run_cur, word_cur, c - 3);
        end
    endtask

    task automatic t_reset_state();
        #1;
        check("R8 reset", {lane_oe, lane_clk, lane_data}, 5'b00000);
    endtask

    task automatic t_rising_capture();
        strobe_rise = 1'b1;
        pix_clk     = 1'b0;
        forget_lock();
        @(negedge bit_clk);
        pd_n = 1'b1;
        repeat (4) @(negedge bit_clk);
        check("R7 acquire after release", {lane_oe, lane_clk, lane_data}, 5'b10000);
        pix_period("R7 R1 R3 R5", 21'h000001);
        pix_period("R7 R1 R3 R5", 21'h100000);
        pix_period("R7 R1 R3 R4", 21'h0AAAAA);
        for (int i = 0; i < 6; i++)
            pix_period("R1 R3 R4 R5", 21'((i + 1) * 32'h0013_579B));
        pix_period("R1 R3 R4 R5", 21'h1FFFFF);
        pix_period("R1 R3 R4 R5", 21'h040201);
    endtask

    task automatic t_clock_loss_and_restart();
        pix_word = 21'h1FFFFF;
        last_din = 21'h1FFFFF;
        repeat (40) @(negedge bit_clk);
        check("R6 lanes low on missing clock", {lane_oe, lane_clk, lane_data}, 5'b10000);
        repeat (5) @(negedge bit_clk);
        check("R6 still low", {lane_oe, lane_clk, lane_data}, 5'b10000);
        forget_lock();
        for (int i = 0; i < 6; i++)
            pix_period("R9 R7 R3", 21'((i + 7) * 32'h0009_7531));
    endtask

    task automatic t_power_down_falling();
        @(negedge bit_clk);
        pd_n = 1'b0;
        #1;
        check("R8 async power-down", {lane_oe, lane_clk, lane_data}, 5'b00000);
        repeat (3) @(negedge bit_clk);
        check("R8 held off", {lane_oe, lane_clk, lane_data}, 5'b00000);
        strobe_rise = 1'b0;
        pix_clk     = 1'b1;
        forget_lock();
        @(negedge bit_clk);
        pd_n = 1'b1;
        repeat (4) @(negedge bit_clk);
        check("R7 acquire falling", {lane_oe, lane_clk, lane_data}, 5'b10000);
        for (int i = 0; i < 7; i++)
            pix_period("R2 R3 R4 R5", 21'((i + 3) * 32'h0015_0F0D));
        pix_period("R2 R3", 21'h155555);
        pix_period("R2 R3", 21'h000000);
    endtask

    initial begin
        t_reset_state();
        t_rising_capture();
        t_clock_loss_and_restart();
        t_power_down_falling();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge bit_clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule